// File: doc/BRIEF.md
# Banked Program Status Register Unit

This unit holds the processor status state of a small 32-bit core that has several privilege modes. It keeps the live status word as separate flag, mask, state and mode registers. It also holds one saved status copy for each exception mode that has one, and it holds the program counter. The core reads and writes the live status word as one packed 32-bit value. The unit checks every mode-field write against the list of legal encodings and refuses any value that is not on the list.

Accesses to "the" saved status copy go to the copy that belongs to the mode in force, with no further decoding by the core. An access made from a mode that has no copy returns zero, changes nothing and pulses an error strobe. The program counter is stored aligned: the low bit is forced clear while the compressed-instruction state bit is set, and the low two bits are forced clear while it is clear. All writes take effect on the rising clock edge. All reads are combinational from the registers. The error strobes are registered and are high in the cycle after the access that caused them.

Top module: `psr_bank_unit`

## Requirements
- R1: The packed status word reads negative at bit 31, zero at bit 30, carry at bit 29, overflow at bit 28, interrupt mask at bit 7, fast interrupt mask at bit 6, state bit at bit 5 and mode at bits 4:0. Every other bit reads 0.
- R2: A status word write loads every flag, both masks and the state bit from the bit positions of R1. A write whose mode value is illegal still updates these fields.
- R3: The legal mode encodings are user 5'b10000, fast interrupt 5'b10001, interrupt 5'b10010, supervisor 5'b10011, abort 5'b10111, undefined 5'b11011 and system 5'b11111. A write of any other mode keeps the old mode, and `err_bad_mode` is then high for exactly the next cycle.
- R4: After reset the status word reads 32'h0000_00D3 (supervisor, both masks set, state bit clear, flags zero). All saved copies and the program counter read zero, and all strobes are low.
- R5: The fast interrupt, interrupt, supervisor, abort and undefined modes each own a separate saved copy. A saved-copy read or write reaches only the copy of the current mode.
- R6: In user or system mode a saved-copy read returns zero and a saved-copy write is discarded. `err_priv` is high for the cycle after such an access.
- R7: A saved-copy access while the mode field is unrecognised pulses `err_inval`. Because R3 keeps the mode legal, this strobe stays low in operation.
- R8: A program counter write clears bit 0 while the state bit is 1, and clears bits 1:0 while it is 0.
- R9: When a status word write falls in the same cycle as a saved-copy write or a program counter write, the saved-copy write is steered by the mode that held before the edge. The program counter write is likewise masked by the state bit that held before the edge.
- R10: `sw_rdata` and `sv_rdata` follow the register state combinationally, with no added cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| sw_we | input | 1 | Status word write enable |
| sw_wdata | input | 32 | Status word write value |
| sw_rdata | output | 32 | Packed status word |
| sv_re | input | 1 | Saved-copy read request (used for error reporting) |
| sv_we | input | 1 | Saved-copy write enable |
| sv_wdata | input | 32 | Saved-copy write value |
| sv_rdata | output | 32 | Saved copy of the current mode, or zero |
| pc_we | input | 1 | Program counter write enable |
| pc_wdata | input | 32 | Program counter write value |
| pc_q | output | 32 | Aligned program counter |
| err_bad_mode | output | 1 | Illegal mode write strobe |
| err_priv | output | 1 | Saved-copy access from user or system mode |
| err_inval | output | 1 | Saved-copy access with an unrecognised mode |

## Verification
Two pairs of functions can land in the same cycle. A status word write that changes the mode can coincide with a saved-copy write. A status word write that flips the state bit can coincide with a program counter write. The bench drives each pair on a single edge. It then judges the first pair by reading back both the old mode's copy and the new mode's copy, and judges the second by the alignment of the stored program counter, which must follow the state bit held before the edge.

// File: rtl/psr_pkg.sv
package psr_pkg;
  localparam int MODE_W = 5;
  localparam int NBANK  = 5;
  localparam int IDX_W  = $clog2(NBANK);

  localparam logic [MODE_W-1:0] M_USR = 5'b10000;
  localparam logic [MODE_W-1:0] M_FIQ = 5'b10001;
  localparam logic [MODE_W-1:0] M_IRQ = 5'b10010;
  localparam logic [MODE_W-1:0] M_SVC = 5'b10011;
  localparam logic [MODE_W-1:0] M_ABT = 5'b10111;
  localparam logic [MODE_W-1:0] M_UND = 5'b11011;
  localparam logic [MODE_W-1:0] M_SYS = 5'b11111;

  // bit positions counted from the top or bottom of the word
  localparam int OFS_NEG = 0;  // offset from MSB
  localparam int OFS_ZER = 1;
  localparam int OFS_CAR = 2;
  localparam int OFS_OVF = 3;
  localparam int POS_IM  = 7;
  localparam int POS_FM  = 6;
  localparam int POS_ST  = 5;
endpackage

// File: rtl/psr_mode_check.sv
module psr_mode_check
  import psr_pkg::*;
(
  input  logic [MODE_W-1:0] mode,
  output logic              legal,
  output logic              banked,
  output logic [IDX_W-1:0]  idx
);
  always_comb begin
    legal  = 1'b1;
    banked = 1'b1;
    idx    = '0;
    unique case (mode)
      M_FIQ: idx = IDX_W'(0);
      M_IRQ: idx = IDX_W'(1);
      M_SVC: idx = IDX_W'(2);
      M_ABT: idx = IDX_W'(3);
      M_UND: idx = IDX_W'(4);
      M_USR, M_SYS: banked = 1'b0;
      default: begin
        legal  = 1'b0;
        banked = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/psr_spsr_bank.sv
module psr_spsr_bank #(
  parameter int DATA_W = 32,
  parameter int NB     = 5,
  localparam int IW    = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [IW-1:0]     idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] store [NB];

  for (genvar b = 0; b < NB; b++) begin : g_bank
    always_ff @(posedge clk) begin
      if (rst)
        store[b] <= '0;
      else if (we && (idx == IW'(b)))
        store[b] <= wdata;
    end
    // R5: a copy that is not selected never changes
    p_bank_isolated_r5: assert property (@(posedge clk) disable iff (rst)
      !(we && (idx == IW'(b))) |=> $stable(store[b]));
  end

  always_comb begin
    rdata = '0;
    for (int k = 0; k < NB; k++)
      if (idx == IW'(k)) rdata = store[k];
  end
endmodule

// File: rtl/psr_pc_align.sv
module psr_pc_align #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic              half_mode,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] pc_q
);
  logic [1:0] low_mask;
  assign low_mask = half_mode ? 2'b10 : 2'b00;

  always_ff @(posedge clk) begin
    if (rst)
      pc_q <= '0;
    else if (we)
      pc_q <= {wdata[DATA_W-1:2], wdata[1:0] & low_mask};
  end

  p_pc_half_r8: assert property (@(posedge clk) disable iff (rst)
    (we && half_mode) |=> (pc_q[0] == 1'b0 && pc_q[DATA_W-1:1] == $past(wdata[DATA_W-1:1])));
  p_pc_word_r8: assert property (@(posedge clk) disable iff (rst)
    (we && !half_mode) |=> (pc_q[1:0] == 2'b00 && pc_q[DATA_W-1:2] == $past(wdata[DATA_W-1:2])));
endmodule

// File: rtl/psr_bank_unit.sv
module psr_bank_unit
  import psr_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sw_we,
  input  logic [DATA_W-1:0] sw_wdata,
  output logic [DATA_W-1:0] sw_rdata,
  input  logic              sv_re,
  input  logic              sv_we,
  input  logic [DATA_W-1:0] sv_wdata,
  output logic [DATA_W-1:0] sv_rdata,
  input  logic              pc_we,
  input  logic [DATA_W-1:0] pc_wdata,
  output logic [DATA_W-1:0] pc_q,
  output logic              err_bad_mode,
  output logic              err_priv,
  output logic              err_inval
);
  localparam int B_NEG = DATA_W - 1 - OFS_NEG;
  localparam int B_ZER = DATA_W - 1 - OFS_ZER;
  localparam int B_CAR = DATA_W - 1 - OFS_CAR;
  localparam int B_OVF = DATA_W - 1 - OFS_OVF;

  logic              f_n, f_z, f_c, f_v, m_irq, m_fiq, st_half;
  logic [MODE_W-1:0] mode_q;

  logic             cur_legal, cur_banked, wr_legal, wr_banked_unused;
  logic [IDX_W-1:0] cur_idx, wr_idx_unused;
  logic [DATA_W-1:0] bank_rd;
  logic              sv_access;

  psr_mode_check u_cur_chk (
    .mode(mode_q), .legal(cur_legal), .banked(cur_banked), .idx(cur_idx));

  psr_mode_check u_wr_chk (
    .mode(sw_wdata[MODE_W-1:0]), .legal(wr_legal),
    .banked(wr_banked_unused), .idx(wr_idx_unused));

  always_ff @(posedge clk) begin
    if (rst) begin
      {f_n, f_z, f_c, f_v} <= '0;
      m_irq   <= 1'b1;
      m_fiq   <= 1'b1;
      st_half <= 1'b0;
      mode_q  <= M_SVC;
    end else if (sw_we) begin
      f_n     <= sw_wdata[B_NEG];
      f_z     <= sw_wdata[B_ZER];
      f_c     <= sw_wdata[B_CAR];
      f_v     <= sw_wdata[B_OVF];
      m_irq   <= sw_wdata[POS_IM];
      m_fiq   <= sw_wdata[POS_FM];
      st_half <= sw_wdata[POS_ST];
      if (wr_legal) mode_q <= sw_wdata[MODE_W-1:0];
    end
  end

  assign sv_access = sv_re | sv_we;

  always_ff @(posedge clk) begin
    if (rst) begin
      err_bad_mode <= 1'b0;
      err_priv     <= 1'b0;
      err_inval    <= 1'b0;
    end else begin
      err_bad_mode <= sw_we & ~wr_legal;
      err_priv     <= sv_access & cur_legal & ~cur_banked;
      err_inval    <= sv_access & ~cur_legal;
    end
  end

  psr_spsr_bank #(.DATA_W(DATA_W), .NB(NBANK)) u_bank (
    .clk(clk), .rst(rst), .we(sv_we & cur_banked), .idx(cur_idx),
    .wdata(sv_wdata), .rdata(bank_rd));

  psr_pc_align #(.DATA_W(DATA_W)) u_pc (
    .clk(clk), .rst(rst), .we(pc_we), .half_mode(st_half),
    .wdata(pc_wdata), .pc_q(pc_q));

  always_comb begin
    sw_rdata                = '0;
    sw_rdata[B_NEG]         = f_n;
    sw_rdata[B_ZER]         = f_z;
    sw_rdata[B_CAR]         = f_c;
    sw_rdata[B_OVF]         = f_v;
    sw_rdata[POS_IM]        = m_irq;
    sw_rdata[POS_FM]        = m_fiq;
    sw_rdata[POS_ST]        = st_half;
    sw_rdata[MODE_W-1:0]    = mode_q;
  end

  assign sv_rdata = cur_banked ? bank_rd : '0;

  // R3/R7: the mode register only ever holds a legal encoding
  p_mode_legal_r7: assert property (@(posedge clk) disable iff (rst) cur_legal);
  // R3: a refused mode write leaves the mode untouched
  p_bad_mode_keeps_r3: assert property (@(posedge clk) disable iff (rst)
    (sw_we && !wr_legal) |=> (mode_q == $past(mode_q)));
  // R3: the strobe follows a status write
  p_bad_mode_cause_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(err_bad_mode) |-> $past(sw_we));
  // R6: the privilege strobe follows a saved-copy access
  p_priv_cause_r6: assert property (@(posedge clk) disable iff (rst)
    err_priv |-> $past(sv_access));
  // R6: an unbanked mode always reads zero
  p_unbanked_zero_r6: assert property (@(posedge clk) disable iff (rst)
    !cur_banked |-> (sv_rdata == '0));
  // R1: unused bits read zero
  p_unused_zero_r1: assert property (@(posedge clk) disable iff (rst)
    (sw_rdata[B_OVF-1:POS_IM+1] == '0));
endmodule

// File: tb/psr_bank_unit_tb_top.sv
module psr_bank_unit_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;  // 125 MHz

  logic        sw_we = 0, sv_re = 0, sv_we = 0, pc_we = 0;
  logic [31:0] sw_wdata = 0, sv_wdata = 0, pc_wdata = 0;
  logic [31:0] sw_rdata, sv_rdata, pc_q;
  logic        err_bad_mode, err_priv, err_inval;

  psr_bank_unit dut_i (
    .clk(clk), .rst(rst),
    .sw_we(sw_we), .sw_wdata(sw_wdata), .sw_rdata(sw_rdata),
    .sv_re(sv_re), .sv_we(sv_we), .sv_wdata(sv_wdata), .sv_rdata(sv_rdata),
    .pc_we(pc_we), .pc_wdata(pc_wdata), .pc_q(pc_q),
    .err_bad_mode(err_bad_mode), .err_priv(err_priv), .err_inval(err_inval));

  int  n_chk = 0, n_fail = 0;
  bit  done = 0;

  // {write value, expected readback, expected bad-mode strobe}
  localparam logic [64:0] VEC [10] = '{
    {32'hF000_00DF, 32'hF000_00DF, 1'b0},
    {32'h5A5A_5A31, 32'h5000_0031, 1'b0},
    {32'hA000_00C5, 32'hA000_00D1, 1'b1},
    {32'h0000_0012, 32'h0000_0012, 1'b0},
    {32'h0000_0017, 32'h0000_0017, 1'b0},
    {32'h0000_001B, 32'h0000_001B, 1'b0},
    {32'h0000_0010, 32'h0000_0010, 1'b0},
    {32'h0000_00FF, 32'h0000_00FF, 1'b0},
    {32'h0000_0000, 32'h0000_001F, 1'b1},
    {32'h0000_0013, 32'h0000_0013, 1'b0}
  };

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic set_sw(logic [31:0] v);
    sw_we = 1; sw_wdata = v;
    step();
    sw_we = 0;
  endtask

  task automatic wr_sv(logic [31:0] v);
    sv_we = 1; sv_wdata = v;
    step();
    sv_we = 0;
  endtask

  logic [4:0]  bmode [5] = '{5'h11, 5'h12, 5'h13, 5'h17, 5'h1B};

  initial begin
    repeat (3) step();
    rst = 0;
    // R4 reset state
    chk("R4 status", sw_rdata, 32'h0000_00D3);
    chk("R4 saved svc", sv_rdata, 32'h0);
    chk("R4 pc", pc_q, 32'h0);
    chk("R4 strobes", {29'd0, err_bad_mode, err_priv, err_inval}, 32'h0);

    // R1 R2 R3 vector walk
    for (int i = 0; i < 10; i++) begin
      set_sw(VEC[i][64:33]);
      chk($sformatf("R1/R2 vec%0d", i), sw_rdata, VEC[i][32:1]);
      chk($sformatf("R3 strobe vec%0d", i), {31'd0, err_bad_mode}, {31'd0, VEC[i][0]});
      step();
      chk($sformatf("R3 one-cycle vec%0d", i), {31'd0, err_bad_mode}, 32'h0);
    end

    // R5 distinct copies per mode
    for (int k = 0; k < 5; k++) begin
      set_sw({24'h0, 3'b110, bmode[k]});
      wr_sv(32'h1111_0000 + k);
    end
    for (int k = 0; k < 5; k++) begin
      set_sw({24'h0, 3'b110, bmode[k]});
      chk($sformatf("R5 bank%0d", k), sv_rdata, 32'h1111_0000 + k);
    end

    // R6 user and system modes, R10 combinational read
    set_sw(32'h0000_00D0);
    sv_re = 1; sv_we = 1; sv_wdata = 32'hDEAD_BEEF;
    #1 chk("R6/R10 user read zero", sv_rdata, 32'h0);
    step();
    sv_re = 0; sv_we = 0;
    chk("R6 user strobe", {31'd0, err_priv}, 32'h1);
    step();
    chk("R6 strobe clears", {31'd0, err_priv}, 32'h0);
    set_sw(32'h0000_00DF);
    sv_re = 1;
    #1 chk("R6 system read zero", sv_rdata, 32'h0);
    step();
    sv_re = 0;
    chk("R6 system strobe", {31'd0, err_priv}, 32'h1);
    for (int k = 0; k < 5; k++) begin
      set_sw({24'h0, 3'b110, bmode[k]});
      chk($sformatf("R6 discard bank%0d", k), sv_rdata, 32'h1111_0000 + k);
    end

    // R10 read follows the current mode at once after the switch
    set_sw(32'h0000_00D3);
    chk("R10 svc read", sv_rdata, 32'h1111_0002);

    // R9 mode change and saved write in one cycle
    sw_we = 1; sw_wdata = 32'h0000_00D7;
    sv_we = 1; sv_wdata = 32'h0000_CAFE;
    step();
    sw_we = 0; sv_we = 0;
    chk("R9 new mode abort copy untouched", sv_rdata, 32'h1111_0003);
    set_sw(32'h0000_00D3);
    chk("R9 old mode svc copy written", sv_rdata, 32'h0000_CAFE);

    // R8 R9 program counter alignment
    sw_we = 1; sw_wdata = 32'h0000_00F3;
    pc_we = 1; pc_wdata = 32'h1234_5677;
    step();
    sw_we = 0; pc_we = 0;
    chk("R9 pc masked by old state bit", pc_q, 32'h1234_5674);
    chk("R2 state bit set", sw_rdata, 32'h0000_00F3);
    pc_we = 1; pc_wdata = 32'h89AB_CDEF;
    step();
    pc_we = 0;
    chk("R8 half alignment", pc_q, 32'h89AB_CDEE);
    set_sw(32'h0000_00D3);
    pc_we = 1; pc_wdata = 32'h89AB_CDEF;
    step();
    pc_we = 0;
    chk("R8 word alignment", pc_q, 32'h89AB_CDEC);

    // R7 invalid-mode strobe never seen since the mode stays legal
    set_sw(32'h0000_0008);
    sv_re = 1;
    step();
    sv_re = 0;
    chk("R7 mode still legal", sw_rdata, 32'h0000_0013);
    chk("R7 no invalid strobe", {31'd0, err_inval}, 32'h0);

    // R4 reset again clears the copies
    rst = 1;
    step();
    rst = 0;
    chk("R4 reset status", sw_rdata, 32'h0000_00D3);
    chk("R4 reset copy", sv_rdata, 32'h0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule